// File: doc/BRIEF.md
# Inter-Core Wake and Status Controller

This controller sits beside a hub shared by eight cores and gives them two cheap ways to coordinate without polling shared memory. Any core may ask for the run state of any other core, and any core may send a wake signal to any other core. A core that has nothing to do requests low-power idle. The controller holds it idle until some other core signals it.

Wake signals are latched as a sticky pending flag per target core. The flag is only acted on when the target is idle or is about to become idle. A signal that arrives while the target is still busy is therefore not lost. The target's next request to sleep consumes the flag, and the core carries on without stalling.

A typical use is a host that wakes a worker and then sleeps. The worker later signals the host back when its job is done, and the order in which the two events happen does not matter. Instruction execution belongs to the cores themselves. This block only tracks the idle state, the pending flags and the answers to status queries.

Top module: `core_wake_hub`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `idle_out`, `wake_out`, `stat_valid` and `stat_code` are all zero.
- R2: A running core that pulses `idle_req` with no pending flag shows `idle_out` high from the next cycle on. It stays idle until it is signalled or stopped.
- R3: A signal request (`req_op` bit = 1) aimed at an idle core clears that core's `idle_out` one cycle later. In that same cycle the core's `wake_out` is high, and `wake_out` is high for exactly one cycle.
- R4: A signal aimed at a running, non-idle core is held as a pending flag. The core's next `idle_req` keeps `idle_out` low and raises `wake_out` for one cycle.
- R5: A pending flag is cleared in the cycle in which it causes a wake. The following `idle_req` puts the core to sleep.
- R6: While a core's `core_run` is low, its `idle_out` is low, its pending flag is cleared and signals aimed at it are discarded. After restart, its first `idle_req` makes it idle.
- R7: A status query (`req_op` bit = 0) returns the target's state as it was in the request cycle, with one cycle of latency. The answer appears in the requester's 2-bit slice of `stat_code` (bits 2j+1:2j for requester j) together with `stat_valid[j]`, using two's complement: 2'b11 (-1) stopped, 2'b00 running, 2'b01 idling. When `stat_valid[j]` is low, the slice is 2'b00.
- R8: Several signals aimed at the same core in one cycle merge into one pending flag, which a single idle entry consumes.
- R9: An `idle_req` from a stopped core is ignored.
- R10: A host can wake an idle worker and then sleep, and the worker can later wake the host.
- R11: A signal that arrives in the same cycle as the target's `idle_req` counts as pending. The core stays awake and `wake_out` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_run | input | 8 | Per core: 1 running, 0 stopped |
| idle_req | input | 8 | Per core one-cycle request to enter idle |
| req_valid | input | 8 | Per requester: operation request valid |
| req_op | input | 8 | Per requester: 0 status query, 1 signal |
| req_target | input | 24 | Per requester 3-bit target index, requester j in bits 3j+2:3j |
| idle_out | output | 8 | Per core: core is held in idle |
| wake_out | output | 8 | Per core one-cycle wake pulse |
| stat_valid | output | 8 | Per requester: status result valid |
| stat_code | output | 16 | Per requester 2-bit status code |

## Verification
Every cycle, the assertions check the following. A core is never idle while it holds a pending flag. Stopping a core clears both its idle state and its pending flag. A signal to an idle core releases it on the next cycle. A query is always answered one cycle later with a legal code.

Only the bench scenarios can show the ordering behaviour. That covers:
- a signal sent before sleep being kept and consumed exactly once;
- merged signals counting once;
- signals to stopped cores leaving nothing behind;
- the host and worker handshake in both directions.

The bench sweeps every requester against every target for queries and signals.

// File: rtl/core_wake_pkg.sv
// Shared types for the inter-core wake controller.
// Assumes: operation bit 0 = status query, 1 = signal.
package core_wake_pkg;
    typedef enum logic {
        OP_QUERY  = 1'b0,
        OP_SIGNAL = 1'b1
    } wake_op_e;

    // Two's-complement status codes
    localparam logic [1:0] ST_STOPPED = 2'b11;
    localparam logic [1:0] ST_RUNNING = 2'b00;
    localparam logic [1:0] ST_IDLING  = 2'b01;
endpackage

// File: rtl/core_wake_merge.sv
// Folds all signal requests into one hit bit per target core.
// Assumes: target indices are below NUM_CORES. Several requesters hitting
// the same target collapse into a single hit.
module core_wake_merge
    import core_wake_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = $clog2(NUM_CORES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       req_valid,
    input  logic [NUM_CORES-1:0]       req_op,
    input  logic [NUM_CORES*IDX_W-1:0] req_target,
    output logic [NUM_CORES-1:0]       sig_hit
);
    // Per target: OR of every requester that signals it
    always_comb begin
        sig_hit = '0;
        for (int t = 0; t < NUM_CORES; t++) begin
            for (int j = 0; j < NUM_CORES; j++) begin
                if (req_valid[j] && (wake_op_e'(req_op[j]) == OP_SIGNAL) &&
                    (int'(req_target[j*IDX_W +: IDX_W]) == t))
                    sig_hit[t] = 1'b1;
            end
        end
    end

    // R8
    hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sig_hit) |-> (|(req_valid & req_op)));
endmodule

// File: rtl/core_wake_cell.sv
// Idle and pending state for one core.
// Assumes: sig_hit is already merged. A stopped core holds no state.
module core_wake_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic core_run,
    input  logic idle_req,
    input  logic sig_hit,
    output logic idle_q,
    output logic wake_q
);
    logic pend_q;
    logic want;

    // A stored flag or a signal arriving this cycle both count as pending
    assign want = pend_q | sig_hit;

    // Idle, pending and wake-pulse update
    always_ff @(posedge clk) begin
        wake_q <= 1'b0;
        if (!rst_n) begin
            idle_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!core_run) begin
            idle_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (idle_q) begin
            if (want) begin
                idle_q <= 1'b0;
                pend_q <= 1'b0;
                wake_q <= 1'b1;
            end
        end else if (idle_req) begin
            if (want) begin
                pend_q <= 1'b0;
                wake_q <= 1'b1;
            end else begin
                idle_q <= 1'b1;
            end
        end else begin
            pend_q <= want;
        end
    end

    // R6
    stopped_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |=> (!idle_q && !pend_q));
    // R5
    idle_pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_q && pend_q));
    // R5
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (!idle_q && !pend_q));
    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && sig_hit && core_run) |=> (wake_q && !idle_q));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !sig_hit && core_run) |=> idle_q);
endmodule

// File: rtl/core_wake_status.sv
// One requester's status port: answers a query one cycle later.
// Assumes: the state vectors are the registered pre-edge core state.
module core_wake_status
    import core_wake_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_op,
    input  logic [IDX_W-1:0]     req_target,
    input  logic [NUM_CORES-1:0] core_run,
    input  logic [NUM_CORES-1:0] core_idle,
    output logic                 stat_valid,
    output logic [1:0]           stat_code
);
    logic       is_query;
    logic [1:0] code_now;

    assign is_query = req_valid && (wake_op_e'(req_op) == OP_QUERY);

    // Encode the target's current state
    always_comb begin
        if (!core_run[req_target])      code_now = ST_STOPPED;
        else if (core_idle[req_target]) code_now = ST_IDLING;
        else                            code_now = ST_RUNNING;
    end

    // Register the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_code  <= 2'b00;
        end else begin
            stat_valid <= is_query;
            stat_code  <= is_query ? code_now : 2'b00;
        end
    end

    // R7
    stat_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_query |=> stat_valid);
    // R7
    stat_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_code != 2'b10));
    // R7
    stat_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> (stat_code == 2'b00));
endmodule

// File: rtl/core_wake_hub.sv
// Top of the inter-core wake and status controller.
// Per-core idle/wake cells, a signal merger and per-requester status ports.
// Assumes: idle_req and req_valid are one-cycle pulses from each core.
module core_wake_hub
    import core_wake_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W    = $clog2(NUM_CORES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       core_run,
    input  logic [NUM_CORES-1:0]       idle_req,
    input  logic [NUM_CORES-1:0]       req_valid,
    input  logic [NUM_CORES-1:0]       req_op,
    input  logic [NUM_CORES*IDX_W-1:0] req_target,
    output logic [NUM_CORES-1:0]       idle_out,
    output logic [NUM_CORES-1:0]       wake_out,
    output logic [NUM_CORES-1:0]       stat_valid,
    output logic [NUM_CORES*2-1:0]     stat_code
);
    logic [NUM_CORES-1:0] sig_hit;

    core_wake_merge #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) merge_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_target(req_target),
        .sig_hit(sig_hit)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cell
        core_wake_cell cell_i (
            .clk(clk), .rst_n(rst_n),
            .core_run(core_run[c]), .idle_req(idle_req[c]),
            .sig_hit(sig_hit[c]),
            .idle_q(idle_out[c]), .wake_q(wake_out[c])
        );
    end

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_stat
        core_wake_status #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) stat_i (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[j]), .req_op(req_op[j]),
            .req_target(req_target[j*IDX_W +: IDX_W]),
            .core_run(core_run), .core_idle(idle_out),
            .stat_valid(stat_valid[j]), .stat_code(stat_code[j*2 +: 2])
        );
    end

    // R9
    stopped_never_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run[0] && idle_req[0]) |=> !idle_out[0]);
endmodule

// File: tb/core_wake_hub_tb.sv
// Bench: sweeps requesters against targets and compares with a bench model.
module core_wake_hub_tb_top;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] core_run = '1, idle_req = '0, req_valid = '0, req_op = '0;
    logic [N*3-1:0] req_target = '0;
    logic [N-1:0] idle_out, wake_out, stat_valid;
    logic [N*2-1:0] stat_code;

    // Bench model state
    logic [N-1:0] m_idle = '0, m_pend = '0, m_wake = '0, m_sv = '0;
    logic [N*2-1:0] m_code = '0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_wake_hub dut_i (
        .clk(clk), .rst_n(rst_n), .core_run(core_run), .idle_req(idle_req),
        .req_valid(req_valid), .req_op(req_op), .req_target(req_target),
        .idle_out(idle_out), .wake_out(wake_out),
        .stat_valid(stat_valid), .stat_code(stat_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Advance one clock: update the model from the requirements, then compare
    task automatic cyc(input string tag);
        logic [N-1:0] hit;
        hit = '0;
        for (int j = 0; j < N; j++)
            if (req_valid[j] && req_op[j]) hit[req_target[j*3 +: 3]] = 1'b1;
        hit &= core_run;
        for (int j = 0; j < N; j++) begin
            int t;
            t = int'(req_target[j*3 +: 3]);
            m_sv[j] = rst_n && req_valid[j] && !req_op[j];
            if (!m_sv[j])          m_code[j*2 +: 2] = 2'b00;
            else if (!core_run[t]) m_code[j*2 +: 2] = 2'b11;
            else if (m_idle[t])    m_code[j*2 +: 2] = 2'b01;
            else                   m_code[j*2 +: 2] = 2'b00;
        end
        for (int t = 0; t < N; t++) begin
            m_wake[t] = 1'b0;
            if (!rst_n || !core_run[t]) begin
                m_idle[t] = 1'b0; m_pend[t] = 1'b0;
            end else if (m_idle[t]) begin
                if (m_pend[t] || hit[t]) begin
                    m_idle[t] = 1'b0; m_pend[t] = 1'b0; m_wake[t] = 1'b1;
                end
            end else if (idle_req[t]) begin
                if (m_pend[t] || hit[t]) begin
                    m_pend[t] = 1'b0; m_wake[t] = 1'b1;
                end else m_idle[t] = 1'b1;
            end else m_pend[t] = m_pend[t] | hit[t];
        end
        @(posedge clk);
        #1;
        chk(idle_out == m_idle && wake_out == m_wake && stat_valid == m_sv && stat_code == m_code,
            tag, {idle_out, wake_out, stat_code}, {m_idle, m_wake, m_code});
        req_valid = '0; req_op = '0; idle_req = '0;
    endtask

    task automatic sig(input int j, input int t);
        req_valid[j] = 1'b1; req_op[j] = 1'b1; req_target[j*3 +: 3] = 3'(t);
    endtask

    task automatic qry(input int j, input int t);
        req_valid[j] = 1'b1; req_op[j] = 1'b0; req_target[j*3 +: 3] = 3'(t);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R1 reset state
        repeat (3) cyc("R1 in reset");
        chk(idle_out == 0 && wake_out == 0 && stat_valid == 0 && stat_code == 0,
            "R1 reset outputs", {idle_out, wake_out, stat_valid}, 0);
        rst_n = 1'b1;
        cyc("R1 after reset");
        chk(stat_code == 0 && idle_out == 0, "R1 first cycle", {stat_code, idle_out}, 0);

        // R7 running sweep
        for (int j = 0; j < N; j++)
            for (int t = 0; t < N; t++) begin
                qry(j, t); cyc("R7 query running");
                chk(stat_valid[j] && stat_code[j*2 +: 2] == 2'b00, "R7 running code",
                    stat_code[j*2 +: 2], 2'b00);
            end
        // R2 all idle
        idle_req = '1; cyc("R2 enter idle");
        chk(idle_out == '1, "R2 idle_out", idle_out, 8'hff);
        cyc("R2 hold idle");
        chk(idle_out == '1, "R2 stays idle", idle_out, 8'hff);
        for (int j = 0; j < N; j++)
            for (int t = 0; t < N; t++) begin
                qry(j, t); cyc("R7 query idle");
                chk(stat_code[j*2 +: 2] == 2'b01, "R7 idling code", stat_code[j*2 +: 2], 2'b01);
            end
        // R6 stop all
        core_run = '0; cyc("R6 stop");
        chk(idle_out == 0, "R6 stop clears idle", idle_out, 0);
        for (int j = 0; j < N; j++)
            for (int t = 0; t < N; t++) begin
                qry(j, t); cyc("R7 query stopped");
                chk(stat_code[j*2 +: 2] == 2'b11, "R7 stopped code", stat_code[j*2 +: 2], 2'b11);
            end
        core_run = '1; cyc("restart");

        // R3 sweep every requester/target pair
        for (int j = 0; j < N; j++)
            for (int t = 0; t < N; t++) begin
                if (j == t) continue;
                idle_req[t] = 1'b1; cyc("R2 target idle");
                sig(j, t); cyc("R3 signal idle target");
                chk(wake_out[t] && !idle_out[t], "R3 wake", {wake_out[t], idle_out[t]}, 2'b10);
                cyc("R3 pulse end");
                chk(!wake_out[t], "R3 one-cycle pulse", wake_out[t], 0);
            end

        // R4 / R5 sticky early signal
        for (int t = 0; t < N; t++) begin
            sig((t + 1) % N, t); cyc("R4 early signal");
            cyc("R4 gap");
            idle_req[t] = 1'b1; cyc("R4 consume");
            chk(!idle_out[t] && wake_out[t], "R4 consumed", {idle_out[t], wake_out[t]}, 2'b01);
            idle_req[t] = 1'b1; cyc("R5 sleeps after consume");
            chk(idle_out[t], "R5 cleared flag", idle_out[t], 1);
            sig((t + 1) % N, t); cyc("R3 rewake");
        end

        // R8 merge
        for (int j = 1; j < N; j++) sig(j, 0);
        cyc("R8 merged signals");
        idle_req[0] = 1'b1; cyc("R8 consume once");
        chk(!idle_out[0], "R8 consume", idle_out[0], 0);
        idle_req[0] = 1'b1; cyc("R8 second idle");
        chk(idle_out[0], "R8 single flag", idle_out[0], 1);
        sig(1, 0); cyc("R8 rewake");

        // R6 signal to stopped core
        core_run[2] = 1'b0; cyc("R6 stop core");
        sig(3, 2); cyc("R6 signal stopped");
        core_run[2] = 1'b1; cyc("R6 restart");
        idle_req[2] = 1'b1; cyc("R6 idle after restart");
        chk(idle_out[2], "R6 no stale flag", idle_out[2], 1);
        sig(3, 2); cyc("R6 rewake");

        // R6 stopping a core with a pending flag clears it
        sig(4, 5); cyc("R6 pend set");
        core_run[5] = 1'b0; cyc("R6 stop pending");
        core_run[5] = 1'b1; cyc("R6 restart pending");
        idle_req[5] = 1'b1; cyc("R6 pend cleared");
        chk(idle_out[5], "R6 pend cleared by stop", idle_out[5], 1);
        sig(4, 5); cyc("R6 rewake2");

        // R9 idle request while stopped
        core_run[6] = 1'b0; idle_req[6] = 1'b1; cyc("R9 stopped idle_req");
        chk(!idle_out[6], "R9 ignored", idle_out[6], 0);
        core_run[6] = 1'b1; cyc("R9 restart");

        // R11 simultaneous signal and idle_req
        sig(0, 7); idle_req[7] = 1'b1; cyc("R11 same cycle");
        chk(!idle_out[7] && wake_out[7], "R11 stays awake", {idle_out[7], wake_out[7]}, 2'b01);

        // R10 host/worker handshake
        idle_req[1] = 1'b1; cyc("R10 worker sleeps");
        sig(0, 1); cyc("R10 host wakes worker");
        chk(wake_out[1] && !idle_out[1], "R10 worker woke", {wake_out[1], idle_out[1]}, 2'b10);
        idle_req[0] = 1'b1; cyc("R10 host sleeps");
        chk(idle_out[0], "R10 host idle", idle_out[0], 1);
        repeat (3) cyc("R10 worker busy");
        sig(1, 0); cyc("R10 worker wakes host");
        chk(wake_out[0] && !idle_out[0], "R10 host woke", {wake_out[0], idle_out[0]}, 2'b10);
        // R10 reverse order: worker finishes before host sleeps
        sig(1, 0); cyc("R10 early finish");
        idle_req[0] = 1'b1; cyc("R10 host no stall");
        chk(!idle_out[0] && wake_out[0], "R10 host not stuck", {idle_out[0], wake_out[0]}, 2'b01);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule